// File: doc/BRIEF.md
# Architectural Register File with Aliased Special Registers

This block stores the architectural state of a small 32-bit processor. A 6-bit register index addresses it. When bit 5 of the index is clear, the low five bits pick one of the general registers. When bit 5 is set, the low two bits pick one of four special registers: a left-operand scratch register (index 0x20), a right-operand scratch register (0x21), the program counter (0x22) and the flag word (0x23). Special indices 0x24 through 0x3F do not exist.

Two combinational read ports and one synchronous write port use this index space. The sequencer also has dedicated ports: a load and a live output for the program counter, for the flag word and for the stack pointer. The stack pointer can be reached only through its dedicated port. Four single-bit flag outputs decode the flag word.

An access to an index that does not exist sets a sticky error bit. A read port counts as accessing only while its enable is high, so an idle read port with a stray index does not raise the error.

Top module: `arch_regfile`

## Requirements
- R1: After reset, every general register reads zero and so do the two scratch registers, the program counter and the flag word. The stack pointer reads MEM_WORDS-1, which is 1023 by default. The error bit is 0.
- R2: A write with bit 5 of the index clear, to index 0..31, updates that general register at the clock edge. Both read ports return any register independently and combinationally.
- R3: Index 0x20 reaches the left scratch register, 0x21 the right scratch register, 0x22 the program counter and 0x23 the flag word, for both reads and writes. A write to one special register changes no other register.
- R4: The program counter output always equals the register at index 0x22. When the dedicated program-counter load and a general write to 0x22 happen in the same cycle, the dedicated load wins.
- R5: When the dedicated flag load and a general write to 0x23 happen in the same cycle, the dedicated load wins. The flag outputs are taken from the flag word as follows: bit 0 is overflow, bit 1 is zero, bit 2 is sign and bit 3 is parity.
- R6: Any index from 0x24 to 0x3F reads as zero on either port. A write to such an index changes no register.
- R7: An enabled read on either port, or a write, to an index from 0x24 to 0x3F sets the error bit at the next clock edge. Reads whose enable is low never set it.
- R8: The error bit stays set until the clear input is applied. If a clear and a new invalid access happen in the same cycle, the error bit stays set.
- R9: The stack pointer changes only through its dedicated load port, and it holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_a_en | input | 1 | Read port A access strobe (used only for error detection) |
| rd_a_idx | input | 6 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_en | input | 1 | Read port B access strobe |
| rd_b_idx | input | 6 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 6 | General write index |
| wr_data | input | 32 | General write data |
| pc_we | input | 1 | Dedicated program counter load |
| pc_wdata | input | 32 | Program counter load value |
| pc_q | output | 32 | Program counter |
| flag_we | input | 1 | Dedicated flag word load |
| flag_wdata | input | 32 | Flag word load value |
| flag_q | output | 32 | Flag word |
| sp_we | input | 1 | Stack pointer load |
| sp_wdata | input | 32 | Stack pointer load value |
| sp_q | output | 32 | Stack pointer |
| flg_ovf | output | 1 | Overflow flag |
| flg_zero | output | 1 | Zero flag |
| flg_sign | output | 1 | Sign flag |
| flg_par | output | 1 | Parity flag |
| err_clr | input | 1 | Clears the sticky error bit |
| reg_err | output | 1 | Sticky invalid-access error |

## Verification
A wrong decode of the index shows up on the read ports in the same cycle in which the index is presented. A wrong write shows up one edge later, as a changed value at some other index. For that reason, every one of the 64 indices is written and then read back on both ports. The special registers are written in descending order, so that a write that spilled into its neighbours would leave the neighbours with the wrong value. A fault in the error logic, or in the priority between the sequencer loads and the general write, becomes visible on reg_err, pc_q or flag_q at the first edge after the triggering cycle.

// File: rtl/arch_regfile_pkg.sv
package arch_regfile_pkg;
  localparam int unsigned IDX_W = 6;

  typedef enum logic [1:0] {
    SPC_LEFT  = 2'd0,
    SPC_RIGHT = 2'd1,
    SPC_PC    = 2'd2,
    SPC_FLAG  = 2'd3
  } spc_sel_e;

  typedef struct packed {
    logic     valid;
    logic     is_gpr;
    logic     is_spc;
    logic [4:0] gpr;
    spc_sel_e spc;
  } idx_dec_t;
endpackage

// File: rtl/arch_regfile_dec.sv
module arch_regfile_dec
  import arch_regfile_pkg::*;
#(
  parameter int unsigned NGPR = 32
) (
  input  logic [IDX_W-1:0] idx,
  output idx_dec_t         dec
);
  always_comb begin
    dec.is_gpr = !idx[5] && (32'(idx[4:0]) < 32'(NGPR));
    dec.is_spc = idx[5] && (idx[4:2] == 3'd0);
    dec.valid  = dec.is_gpr || dec.is_spc;
    dec.gpr    = idx[4:0];
    dec.spc    = spc_sel_e'(idx[1:0]);
  end
endmodule

// File: rtl/arch_regfile_gpr.sv
module arch_regfile_gpr #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NGPR = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [4:0]                waddr,
  input  logic [DW-1:0]             wdata,
  output logic [NGPR-1:0][DW-1:0]   q
);
  for (genvar g = 0; g < NGPR; g++) begin : g_reg
    logic en;
    assign en = we && (32'(waddr) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[g] <= '0;
      else if (en) q[g] <= wdata;
    end
  end
endmodule

// File: rtl/arch_regfile_spc.sv
module arch_regfile_spc
  import arch_regfile_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned MEM_WORDS = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_we,
  input  spc_sel_e      gen_sel,
  input  logic [DW-1:0] gen_wdata,
  input  logic          pc_we,
  input  logic [DW-1:0] pc_wdata,
  input  logic          flag_we,
  input  logic [DW-1:0] flag_wdata,
  input  logic          sp_we,
  input  logic [DW-1:0] sp_wdata,
  output logic [DW-1:0] left_q,
  output logic [DW-1:0] right_q,
  output logic [DW-1:0] pc_q,
  output logic [DW-1:0] flag_q,
  output logic [DW-1:0] sp_q
);
  localparam logic [DW-1:0] SP_RESET = DW'(MEM_WORDS - 1);

  logic [DW-1:0] left_d, right_d, pc_d, flag_d, sp_d;

  always_comb begin
    left_d  = left_q;
    right_d = right_q;
    pc_d    = pc_q;
    flag_d  = flag_q;
    sp_d    = sp_q;
    if (gen_we) begin
      unique case (gen_sel)
        SPC_LEFT:  left_d  = gen_wdata;
        SPC_RIGHT: right_d = gen_wdata;
        SPC_PC:    pc_d    = gen_wdata;
        SPC_FLAG:  flag_d  = gen_wdata;
        default:   ;
      endcase
    end
    if (pc_we)   pc_d   = pc_wdata;
    if (flag_we) flag_d = flag_wdata;
    if (sp_we)   sp_d   = sp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      pc_q    <= '0;
      flag_q  <= '0;
      sp_q    <= SP_RESET;
    end else begin
      left_q  <= left_d;
      right_q <= right_d;
      pc_q    <= pc_d;
      flag_q  <= flag_d;
      sp_q    <= sp_d;
    end
  end
endmodule

// File: rtl/arch_regfile_rdmux.sv
module arch_regfile_rdmux
  import arch_regfile_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned NGPR = 32
) (
  input  idx_dec_t                dec,
  input  logic [NGPR-1:0][DW-1:0] gpr,
  input  logic [DW-1:0]           left_q,
  input  logic [DW-1:0]           right_q,
  input  logic [DW-1:0]           pc_q,
  input  logic [DW-1:0]           flag_q,
  output logic [DW-1:0]           data
);
  localparam int unsigned SELW = (NGPR > 1) ? $clog2(NGPR) : 1;

  always_comb begin
    data = '0;
    if (dec.is_gpr) begin
      data = gpr[dec.gpr[SELW-1:0]];
    end else if (dec.is_spc) begin
      unique case (dec.spc)
        SPC_LEFT:  data = left_q;
        SPC_RIGHT: data = right_q;
        SPC_PC:    data = pc_q;
        SPC_FLAG:  data = flag_q;
        default:   data = '0;
      endcase
    end
  end
endmodule

// File: rtl/arch_regfile.sv
module arch_regfile
  import arch_regfile_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned NGPR      = 32,
  parameter int unsigned MEM_WORDS = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_a_en,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [DW-1:0]    rd_a_data,
  input  logic             rd_b_en,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [DW-1:0]    rd_b_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             pc_we,
  input  logic [DW-1:0]    pc_wdata,
  output logic [DW-1:0]    pc_q,
  input  logic             flag_we,
  input  logic [DW-1:0]    flag_wdata,
  output logic [DW-1:0]    flag_q,
  input  logic             sp_we,
  input  logic [DW-1:0]    sp_wdata,
  output logic [DW-1:0]    sp_q,
  output logic             flg_ovf,
  output logic             flg_zero,
  output logic             flg_sign,
  output logic             flg_par,
  input  logic             err_clr,
  output logic             reg_err
);
  // reset synchronizer: assert asynchronously, release on the clock
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  idx_dec_t dec_a, dec_b, dec_w;
  arch_regfile_dec #(.NGPR(NGPR)) u_dec_a (.idx(rd_a_idx), .dec(dec_a));
  arch_regfile_dec #(.NGPR(NGPR)) u_dec_b (.idx(rd_b_idx), .dec(dec_b));
  arch_regfile_dec #(.NGPR(NGPR)) u_dec_w (.idx(wr_idx),   .dec(dec_w));

  logic [NGPR-1:0][DW-1:0] gpr_q;
  logic [DW-1:0] left_q, right_q;

  arch_regfile_gpr #(.DW(DW), .NGPR(NGPR)) u_gpr (
    .clk(clk), .rst_n(rst_q_n),
    .we(wr_en && dec_w.is_gpr), .waddr(dec_w.gpr), .wdata(wr_data),
    .q(gpr_q)
  );

  arch_regfile_spc #(.DW(DW), .MEM_WORDS(MEM_WORDS)) u_spc (
    .clk(clk), .rst_n(rst_q_n),
    .gen_we(wr_en && dec_w.is_spc), .gen_sel(dec_w.spc), .gen_wdata(wr_data),
    .pc_we(pc_we), .pc_wdata(pc_wdata),
    .flag_we(flag_we), .flag_wdata(flag_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata),
    .left_q(left_q), .right_q(right_q), .pc_q(pc_q), .flag_q(flag_q), .sp_q(sp_q)
  );

  arch_regfile_rdmux #(.DW(DW), .NGPR(NGPR)) u_rd_a (
    .dec(dec_a), .gpr(gpr_q), .left_q(left_q), .right_q(right_q),
    .pc_q(pc_q), .flag_q(flag_q), .data(rd_a_data)
  );
  arch_regfile_rdmux #(.DW(DW), .NGPR(NGPR)) u_rd_b (
    .dec(dec_b), .gpr(gpr_q), .left_q(left_q), .right_q(right_q),
    .pc_q(pc_q), .flag_q(flag_q), .data(rd_b_data)
  );

  assign flg_ovf  = flag_q[0];
  assign flg_zero = flag_q[1];
  assign flg_sign = flag_q[2];
  assign flg_par  = flag_q[3];

  // sticky error: a new invalid access dominates a clear
  logic err_set, err_d;
  always_comb begin
    err_set = (rd_a_en && !dec_a.valid) || (rd_b_en && !dec_b.valid) ||
              (wr_en && !dec_w.valid);
    err_d   = err_set || (reg_err && !err_clr);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) reg_err <= 1'b0;
    else          reg_err <= err_d;
  end
endmodule

// File: rtl/arch_regfile_chk.sv
module arch_regfile_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          rd_a_en,
  input logic [5:0]    rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic          rd_b_en,
  input logic [5:0]    rd_b_idx,
  input logic [DW-1:0] rd_b_data,
  input logic          wr_en,
  input logic [5:0]    wr_idx,
  input logic          pc_we,
  input logic [DW-1:0] pc_wdata,
  input logic [DW-1:0] pc_q,
  input logic          flag_we,
  input logic [DW-1:0] flag_wdata,
  input logic [DW-1:0] flag_q,
  input logic          sp_we,
  input logic [DW-1:0] sp_wdata,
  input logic [DW-1:0] sp_q,
  input logic          err_clr,
  input logic          reg_err
);
  logic a_bad, b_bad, w_bad;
  assign a_bad = rd_a_idx[5] && (rd_a_idx[4:2] != 3'd0);
  assign b_bad = rd_b_idx[5] && (rd_b_idx[4:2] != 3'd0);
  assign w_bad = wr_idx[5]   && (wr_idx[4:2]   != 3'd0);

  // R6
  inv_read_a_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    a_bad |-> rd_a_data == '0);
  // R6
  inv_read_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    b_bad |-> rd_b_data == '0);
  // R7
  err_on_bad_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && w_bad) |=> reg_err);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_err && !err_clr) |=> reg_err);
  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (err_clr && !(rd_a_en && a_bad) && !(rd_b_en && b_bad) && !(wr_en && w_bad))
      |=> !reg_err);
  // R4
  pc_load_prio_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    pc_we |=> pc_q == $past(pc_wdata));
  // R5
  flag_load_prio_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    flag_we |=> flag_q == $past(flag_wdata));
  // R9
  sp_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    sp_we |=> sp_q == $past(sp_wdata));
  // R9
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !sp_we |=> $stable(sp_q));
endmodule

bind arch_regfile arch_regfile_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n),
  .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx),
  .pc_we(pc_we), .pc_wdata(pc_wdata), .pc_q(pc_q),
  .flag_we(flag_we), .flag_wdata(flag_wdata), .flag_q(flag_q),
  .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_q(sp_q),
  .err_clr(err_clr), .reg_err(reg_err)
);

// File: tb/tb_arch_regfile.sv
module tb_arch_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_a_en, rd_b_en, wr_en, pc_we, flag_we, sp_we, err_clr;
  logic [5:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, pc_wdata, pc_q;
  logic [31:0] flag_wdata, flag_q, sp_wdata, sp_q;
  logic        flg_ovf, flg_zero, flg_sign, flg_par, reg_err;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  arch_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .pc_q(pc_q),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .flag_q(flag_q),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_q(sp_q),
    .flg_ovf(flg_ovf), .flg_zero(flg_zero), .flg_sign(flg_sign), .flg_par(flg_par),
    .err_clr(err_clr), .reg_err(reg_err)
  );

  function automatic logic [31:0] pat(int i);
    return 32'h1357_9BDF ^ (32'(i) * 32'h0101_0103);
  endfunction

  function automatic logic [31:0] expect_model(int i);
    return (i < 36) ? pat(i) : 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_both(logic [5:0] ia, logic [5:0] ib);
    rd_a_idx = ia; rd_b_idx = ib;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    {rd_a_en, rd_b_en, wr_en, pc_we, flag_we, sp_we, err_clr} = '0;
    rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0;
    wr_data = '0; pc_wdata = '0; flag_wdata = '0; sp_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state swept over the whole index space
    for (int i = 0; i < 64; i++) begin
      rd_both(6'(i), 6'(63 - i));
      chk("R1 reset read A", rd_a_data, 32'h0);
    end
    chk("R1 sp reset", sp_q, 32'd1023);
    chk("R1 pc reset", pc_q, 32'h0);
    chk("R1 err reset", {31'h0, reg_err}, 32'h0);

    // R2: fill general registers
    for (int i = 0; i < 32; i++) wr(6'(i), pat(i));
    // R3: specials in descending order exposes any spill into neighbours
    for (int i = 35; i >= 32; i--) wr(6'(i), pat(i));
    for (int i = 0; i < 36; i++) begin
      rd_both(6'(i), 6'(35 - i));
      chk(i < 32 ? "R2 read A" : "R3 read A", rd_a_data, pat(i));
      chk(i >= 4 ? "R2 read B" : "R3 read B", rd_b_data, pat(35 - i));
    end
    chk("R4 pc alias", pc_q, pat(34));
    chk("R5 flag bits", {28'h0, flg_par, flg_sign, flg_zero, flg_ovf}, {28'h0, pat(35)[3:0]});
    chk("R7 no err after valid", {31'h0, reg_err}, 32'h0);

    // R6/R7: unenabled invalid reads return zero and raise nothing
    for (int i = 36; i < 64; i++) begin
      rd_both(6'(i), 6'(i));
      chk("R6 invalid read A", rd_a_data, 32'h0);
      chk("R6 invalid read B", rd_b_data, 32'h0);
    end
    @(negedge clk);
    chk("R7 idle invalid read no err", {31'h0, reg_err}, 32'h0);

    // R7: enabled invalid read on port A, then on port B
    rd_a_en = 1'b1; rd_a_idx = 6'd40;
    @(negedge clk); rd_a_en = 1'b0;
    chk("R7 port A invalid sets err", {31'h0, reg_err}, 32'h1);
    // R8: sticky for several cycles
    repeat (3) @(negedge clk);
    chk("R8 err sticky", {31'h0, reg_err}, 32'h1);
    err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk("R8 err cleared", {31'h0, reg_err}, 32'h0);
    rd_b_en = 1'b1; rd_b_idx = 6'd63;
    @(negedge clk); rd_b_en = 1'b0;
    chk("R7 port B invalid sets err", {31'h0, reg_err}, 32'h1);
    // R8: clear and new error together keeps err set
    err_clr = 1'b1; wr_en = 1'b1; wr_idx = 6'd36; wr_data = 32'hFFFF_FFFF;
    @(negedge clk); err_clr = 1'b0; wr_en = 1'b0;
    chk("R8 set beats clear", {31'h0, reg_err}, 32'h1);
    err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk("R8 err cleared again", {31'h0, reg_err}, 32'h0);

    // R6: writes to every invalid index change nothing
    for (int i = 36; i < 64; i++) wr(6'(i), 32'hFFFF_FFFF);
    chk("R7 invalid write sets err", {31'h0, reg_err}, 32'h1);
    for (int i = 0; i < 64; i++) begin
      rd_both(6'(i), 6'(i));
      chk("R6 state after invalid writes", rd_a_data, expect_model(i));
    end
    chk("R9 sp unchanged", sp_q, 32'd1023);

    // R4: dedicated load beats general write to 0x22
    @(negedge clk);
    pc_we = 1'b1; pc_wdata = 32'hCAFE_0001;
    wr_en = 1'b1; wr_idx = 6'h22; wr_data = 32'hDEAD_0002;
    @(negedge clk); pc_we = 1'b0; wr_en = 1'b0;
    chk("R4 pc priority", pc_q, 32'hCAFE_0001);
    rd_both(6'h22, 6'h21);
    chk("R4 pc via index", rd_a_data, 32'hCAFE_0001);
    chk("R3 neighbour of pc", rd_b_data, pat(33));

    // R5: dedicated flag load beats general write to 0x23; sweep flag nibble
    @(negedge clk);
    flag_we = 1'b1; flag_wdata = 32'h0000_0005;
    wr_en = 1'b1; wr_idx = 6'h23; wr_data = 32'h0000_000A;
    @(negedge clk); flag_we = 1'b0; wr_en = 1'b0;
    chk("R5 flag priority", flag_q, 32'h5);
    for (int v = 0; v < 16; v++) begin
      flag_we = 1'b1; flag_wdata = 32'(v) | 32'hA500_0000;
      @(negedge clk); flag_we = 1'b0;
      chk("R5 flag outputs", {28'h0, flg_par, flg_sign, flg_zero, flg_ovf}, 32'(v));
    end

    // R9: dedicated stack pointer load
    sp_we = 1'b1; sp_wdata = 32'd5;
    @(negedge clk); sp_we = 1'b0;
    chk("R9 sp load", sp_q, 32'd5);
    wr(6'h22, 32'h1234);
    chk("R9 sp holds", sp_q, 32'd5);
    chk("R3 pc general write", pc_q, 32'h1234);

    finish_run();
  end
endmodule